// File: doc/BRIEF.md
# Diagnostic Scratch Pad RAM Window

This block gives a processor a small private workspace for use while it tests itself. A one-bit diagnostic I/O write sets or clears an enable latch. While the latch is set, the processor's word reads and writes that fall inside a 256-byte address window are served by a local RAM of 128 words of 16 bits. All other processor cycles are handed on to the external system bus.

For every processor request the block drives one of two routing outputs in the same cycle. `claim_local` means the access is served here. `pass_ext` means the external bus cycle should start. Read data from the local RAM comes back on the clock edge after the request, together with a one-cycle valid strobe. The RAM is only reachable through the processor port, so no external bus master can see or change its contents. The latch resets to zero, so the window is closed after power-up.

Top module: `diag_scratch_window`

## Requirements
- R1: After a synchronous active-low reset, `diag_en` is 0 and `rd_valid` is 0.
- R2: An I/O write (`io_wr`=1) with `io_addr`=16'hFAFE, `io_bit`=2 and `io_data`=1 sets `diag_en` on the next clock edge. Bits are numbered with bit 0 as the most significant bit of the register. A write to any other bit index or any other I/O address leaves `diag_en` unchanged.
- R3: The same I/O write with `io_data`=0 clears `diag_en` on the next clock edge.
- R4: While `diag_en`=1, a request (`cpu_req`=1) whose byte address lies in 16'hFA00..16'hFAFF drives `claim_local`=1 and `pass_ext`=0 in the same cycle.
- R5: A request made while `diag_en`=0, or to an address outside the window, drives `pass_ext`=1 and `claim_local`=0. With `cpu_req`=0 both outputs are 0.
- R6: The RAM word is selected by `cpu_addr[7:1]`. Address bit 0 has no effect, so the two byte addresses of one word reach the same storage.
- R7: A claimed read (`cpu_we`=0) presents `rd_valid`=1 and the stored word on `rd_data` exactly one clock edge after the request, for one cycle. A claimed write (`cpu_we`=1) stores `cpu_wdata` at that edge, and a read in the very next cycle returns it.
- R8: `rd_valid` stays 0 for writes and for passed-on requests, and `rd_data` is all zeros whenever `rd_valid` is 0.
- R9: Requests that are passed on (latch clear, or address outside the window) never change RAM contents. Words written earlier read back unchanged after the latch is cleared and set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Single-bit I/O write strobe |
| io_addr | input | 16 | I/O register address of the write |
| io_bit | input | 4 | Bit index within the register, 0 = MSB |
| io_data | input | 1 | Value of the bit being written |
| diag_en | output | 1 | Current state of the diagnostic enable latch |
| cpu_req | input | 1 | Processor memory request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 16 | Processor write word |
| claim_local | output | 1 | Access is served by the scratch RAM |
| pass_ext | output | 1 | Access must start on the external bus |
| rd_valid | output | 1 | Read data strobe, one cycle |
| rd_data | output | 16 | Read word, zero when not valid |

## Verification
The routing outputs are combinational, so the bench checks them one nanosecond after it drives a request, inside the same cycle. A latch write takes effect on the following edge, so `diag_en` is checked at the falling edge after that edge. Each claimed read is queued with a due cycle one edge after the request. A falling-edge monitor compares `rd_valid` and `rd_data` against the head of the queue in exactly that cycle. In every other cycle it treats any strobe, or any nonzero `rd_data`, as a failure.

// File: rtl/scratch_pkg.sv
// Package: shared defaults and the routing type of the diagnostic scratch window.
// Assumes: a 16-bit processor with byte addresses and word-wide data.
package scratch_pkg;

    localparam int unsigned DEF_ADDR_W = 16;
    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_WORDS  = 128;

    // Where a processor request is steered in the current cycle.
    typedef enum logic [1:0] {
        ROUTE_IDLE  = 2'b00,
        ROUTE_LOCAL = 2'b01,
        ROUTE_EXT   = 2'b10
    } route_e;

endpackage

// File: rtl/diag_latch.sv
// Module: diag_latch
// Holds the diagnostic enable bit. It is written through a single-bit I/O port.
// Assumes: bit indices count from the MSB (index 0 = MSB); only one bit of one
// register address is decoded; all other I/O writes are ignored here.
module diag_latch #(
    parameter int unsigned          ADDR_W  = 16,
    parameter int unsigned          BIT_W   = 4,
    parameter logic [ADDR_W-1:0]    IO_ADDR = 16'hFAFE,
    parameter int unsigned          EN_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BIT_W-1:0]  io_bit,
    input  logic              io_data,
    output logic              en_q
);

    localparam logic [BIT_W-1:0] EN_IDX = BIT_W'(EN_BIT);

    logic sel;

    // Decode a write that targets the enable bit.
    always_comb begin
        sel = io_wr && (io_addr == IO_ADDR) && (io_bit == EN_IDX);
    end

    // Latch the written value; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (sel) begin
            en_q <= io_data;
        end
    end

endmodule

// File: rtl/window_decode.sv
// Module: window_decode
// Compares a processor byte address with the scratch window and picks a route.
// Assumes: the window is 2*WORDS bytes, aligned to its own size; the word
// index is taken from the address bits above bit 0.
module window_decode
    import scratch_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 16,
    parameter int unsigned       IDX_W    = 7,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFA00
) (
    input  logic              req,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output route_e            route,
    output logic [IDX_W-1:0]  idx
);

    localparam int unsigned WIN_LSB = IDX_W + 1;
    localparam logic [ADDR_W-WIN_LSB-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LSB];

    logic in_win;

    // Upper address bits must match the window tag.
    always_comb begin
        in_win = (addr[ADDR_W-1:WIN_LSB] == WIN_TAG);
    end

    // Word index ignores the byte-select bit.
    always_comb begin
        idx = addr[WIN_LSB-1:1];
    end

    // Steer: local only when enabled and inside the window.
    always_comb begin
        if (!req) begin
            route = ROUTE_IDLE;
        end else if (en && in_win) begin
            route = ROUTE_LOCAL;
        end else begin
            route = ROUTE_EXT;
        end
    end

endmodule

// File: rtl/scratch_ram.sv
// Module: scratch_ram
// Single-port word RAM with a registered read port and a one-cycle valid strobe.
// Assumes: read and write are never requested together; contents are not reset.
module scratch_ram #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WORDS  = 128,
    parameter int unsigned IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    // Store the write word at the addressed location.
    always_ff @(posedge clk) begin
        if (wr) begin
            mem[idx] <= wdata;
        end
    end

    // Register the addressed word on a read.
    always_ff @(posedge clk) begin
        if (rd) begin
            rdata <= mem[idx];
        end
    end

    // Strobe valid for the cycle after each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
        end
    end

endmodule

// File: rtl/diag_scratch_window.sv
// Module: diag_scratch_window (top)
// Diagnostic scratch RAM that overlays a processor address window while the
// enable latch is set. Claims or passes on each request, and returns read data
// one edge after a claimed read.
// Assumes: only processor-originated cycles arrive on the cpu_* port; the
// external bus has no path into this block.
module diag_scratch_window
    import scratch_pkg::*;
#(
    parameter int unsigned       ADDR_W   = DEF_ADDR_W,
    parameter int unsigned       DATA_W   = DEF_DATA_W,
    parameter int unsigned       WORDS    = DEF_WORDS,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFA00,
    parameter logic [ADDR_W-1:0] IO_ADDR  = 16'hFAFE,
    parameter int unsigned       EN_BIT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [3:0]        io_bit,
    input  logic              io_data,
    output logic              diag_en,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              claim_local,
    output logic              pass_ext,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned IDX_W = $clog2(WORDS);
    localparam int unsigned BIT_W = 4;

    route_e            route;
    logic [IDX_W-1:0]  word_idx;
    logic              ram_wr;
    logic              ram_rd;
    logic              ram_vld;
    logic [DATA_W-1:0] ram_q;

    diag_latch #(
        .ADDR_W (ADDR_W),
        .BIT_W  (BIT_W),
        .IO_ADDR(IO_ADDR),
        .EN_BIT (EN_BIT)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .io_wr  (io_wr),
        .io_addr(io_addr),
        .io_bit (io_bit),
        .io_data(io_data),
        .en_q   (diag_en)
    );

    window_decode #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .WIN_BASE(WIN_BASE)
    ) u_decode (
        .req  (cpu_req),
        .en   (diag_en),
        .addr (cpu_addr),
        .route(route),
        .idx  (word_idx)
    );

    // Turn the route into the two steering outputs and the RAM strobes.
    always_comb begin
        claim_local = (route == ROUTE_LOCAL);
        pass_ext    = (route == ROUTE_EXT);
        ram_wr      = claim_local && cpu_we;
        ram_rd      = claim_local && !cpu_we;
    end

    scratch_ram #(
        .DATA_W(DATA_W),
        .WORDS (WORDS),
        .IDX_W (IDX_W)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ram_wr),
        .rd    (ram_rd),
        .idx   (word_idx),
        .wdata (cpu_wdata),
        .rvalid(ram_vld),
        .rdata (ram_q)
    );

    assign rd_valid = ram_vld;

    // Read data mux: gate each bit with the valid strobe so idle cycles read zero.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rd_gate
        assign rd_data[b] = ram_vld & ram_q[b];
    end

endmodule

// File: rtl/diag_scratch_window_chk.sv
// Module: diag_scratch_window_chk
// Property checker for diag_scratch_window, attached by bind below.
// Assumes: it observes only the top-level ports.
module diag_scratch_window_chk #(
    parameter int unsigned       ADDR_W   = 16,
    parameter int unsigned       DATA_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFA00,
    parameter logic [ADDR_W-1:0] IO_ADDR  = 16'hFAFE,
    parameter int unsigned       EN_BIT   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic [ADDR_W-1:0] io_addr,
    input logic [3:0]        io_bit,
    input logic              io_data,
    input logic              diag_en,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              claim_local,
    input logic              pass_ext,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);

    logic en_hit;
    assign en_hit = io_wr && (io_addr == IO_ADDR) && (io_bit == 4'(EN_BIT));

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hit && io_data) |=> diag_en);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_hit |=> $stable(diag_en));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hit && !io_data) |=> !diag_en);

    p_claim_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        claim_local |-> (diag_en && (cpu_addr[ADDR_W-1:8] == WIN_BASE[ADDR_W-1:8])));

    p_route_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> $onehot({claim_local, pass_ext}));

    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> (!claim_local && !pass_ext));

    p_read_due_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_local && !cpu_we) |=> rd_valid);

    p_no_stray_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(claim_local && !cpu_we));

    p_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

endmodule

bind diag_scratch_window diag_scratch_window_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WIN_BASE(WIN_BASE),
    .IO_ADDR (IO_ADDR),
    .EN_BIT  (EN_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr      (io_wr),
    .io_addr    (io_addr),
    .io_bit     (io_bit),
    .io_data    (io_data),
    .diag_en    (diag_en),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .claim_local(claim_local),
    .pass_ext   (pass_ext),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
);

// File: tb/tb_diag_scratch_window.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected reads, and a falling-edge monitor
// pops and compares them in their due cycle.
module tb_diag_scratch_window;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_bit = '0;
    logic        io_data = 1'b0;
    logic        diag_en;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        claim_local;
    logic        pass_ext;
    logic        rd_valid;
    logic [15:0] rd_data;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    bit en_model = 1'b0;
    logic [15:0] model [128];

    typedef struct {
        int          due;
        logic [15:0] data;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    diag_scratch_window dut (
        .clk(clk), .rst_n(rst_n),
        .io_wr(io_wr), .io_addr(io_addr), .io_bit(io_bit), .io_data(io_data),
        .diag_en(diag_en),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .claim_local(claim_local), .pass_ext(pass_ext),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // One single-bit I/O write; diag_en is checked after the capturing edge.
    task automatic io_write(input logic [15:0] a, input logic [3:0] b, input logic d, input string tag);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_bit = b; io_data = d;
        if (a == 16'hFAFE && b == 4'd2) en_model = d;
        @(negedge clk);
        io_wr = 1'b0;
        check(diag_en == en_model, tag, 32'(diag_en), 32'(en_model));
    endtask

    // One processor request; routing checked in-cycle, reads queued one edge ahead.
    task automatic cpu_access(input bit we, input logic [15:0] a, input logic [15:0] wd, input string tag);
        bit hit;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        hit = en_model && (a[15:8] == 8'hFA);
        #1;
        check(claim_local == hit && pass_ext == !hit, tag,
              32'({claim_local, pass_ext}), 32'({hit, !hit}));
        if (hit && we) model[a[7:1]] = wd;
        if (hit && !we) sb_q.push_back('{cyc + 1, model[a[7:1]], tag});
    endtask

    task automatic cpu_idle(input int n);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        #1;
        check(!claim_local && !pass_ext, "R5 idle routing", 32'({claim_local, pass_ext}), 32'h0);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare due reads; any other strobe or nonzero data fails (R7, R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb_q.size() != 0 && sb_q[0].due == cyc) begin
                check(rd_valid === 1'b1, {sb_q[0].tag, " valid (R7)"}, 32'(rd_valid), 32'h1);
                check(rd_data === sb_q[0].data, {sb_q[0].tag, " data (R7)"}, 32'(rd_data), 32'(sb_q[0].data));
                void'(sb_q.pop_front());
            end else begin
                if (rd_valid !== 1'b0) check(1'b0, "R8 stray rd_valid", 32'(rd_valid), 32'h0);
                if (rd_data !== 16'h0) check(1'b0, "R8 rd_data not zero", 32'(rd_data), 32'h0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(diag_en == 1'b0, "R1 diag_en after reset", 32'(diag_en), 32'h0);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", 32'(rd_valid), 32'h0);

        // R5: latch clear, window address passes on
        cpu_access(1'b0, 16'hFA10, 16'h0, "R5 read with latch clear");
        cpu_access(1'b1, 16'hFA10, 16'hDEAD, "R5 write with latch clear");
        cpu_idle(1);

        // R2: wrong bit and wrong address ignored, then a proper set
        io_write(16'hFAFE, 4'd5, 1'b1, "R2 other bit ignored");
        io_write(16'hFAFC, 4'd2, 1'b1, "R2 other address ignored");
        io_write(16'hFAFE, 4'd2, 1'b1, "R2 enable set");

        // R4/R7: writes across the window then back-to-back reads
        cpu_access(1'b1, 16'hFA00, 16'h1234, "R4 write first word");
        cpu_access(1'b1, 16'hFAFE, 16'hA5A5, "R4 write last word");
        cpu_access(1'b1, 16'hFA42, 16'h0F0F, "R4 write mid word");
        cpu_access(1'b1, 16'hFA80, 16'hFFFF, "R4 write upper half");
        cpu_access(1'b0, 16'hFA00, 16'h0, "R7 read first word");
        cpu_access(1'b0, 16'hFAFE, 16'h0, "R7 read last word");
        cpu_access(1'b0, 16'hFA42, 16'h0, "R7 read mid word");
        cpu_access(1'b0, 16'hFA80, 16'h0, "R7 read upper half");
        cpu_idle(2);

        // R6: odd byte address selects the same word
        cpu_access(1'b1, 16'hFA21, 16'hBEEF, "R6 write odd byte address");
        cpu_access(1'b0, 16'hFA20, 16'h0, "R6 read even byte address");
        cpu_access(1'b0, 16'hFA21, 16'h0, "R6 read odd byte address");
        cpu_idle(1);

        // R7: read immediately after write to the same word
        cpu_access(1'b1, 16'hFA66, 16'h5AA5, "R7 write before read");
        cpu_access(1'b0, 16'hFA66, 16'h0, "R7 read right after write");
        cpu_idle(1);

        // R5/R9: outside the window passes on and leaves RAM intact
        cpu_access(1'b1, 16'hFB00, 16'h9999, "R5 write above window");
        cpu_access(1'b1, 16'hF9FE, 16'h8888, "R5 write below window");
        cpu_access(1'b0, 16'hFB00, 16'h0, "R8 read above window");
        cpu_access(1'b0, 16'hFA00, 16'h0, "R9 word 0 after outside writes");
        cpu_access(1'b0, 16'hFAFE, 16'h0, "R9 last word after outside writes");
        cpu_idle(1);

        // R3/R9: clear the latch, write passes on, re-enable, contents retained
        io_write(16'hFAFE, 4'd2, 1'b0, "R3 enable cleared");
        cpu_access(1'b1, 16'hFA42, 16'h7777, "R3 write passes when cleared");
        cpu_access(1'b0, 16'hFA42, 16'h0, "R3 read passes when cleared");
        cpu_idle(1);
        io_write(16'hFAFE, 4'd2, 1'b1, "R2 enable set again");
        cpu_access(1'b0, 16'hFA42, 16'h0, "R9 mid word retained");
        cpu_access(1'b0, 16'hFA20, 16'h0, "R9 odd-written word retained");
        cpu_idle(3);

        check(sb_q.size() == 0, "R7 all reads returned", 32'(sb_q.size()), 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule